// File: doc/BRIEF.md
# Interrupt Request and Response Controller

This block stands between the interrupt request pins of a small processor core and that core's instruction sequencer. It watches two active-low request inputs. The non-maskable input raises one request for each falling edge. The maskable input raises a request for as long as it is held low, but only while the interrupt-enable flag is set. When the sequencer reaches an instruction boundary and a request is pending, the block runs a response of a fixed length. During that response it drives the acknowledge strobes, and in the final cycle it drives a vector-read strobe and a bus status code.

The core sets and clears the interrupt-enable flag with single-cycle pulses. Entering a response clears the flag. An inverted copy of the flag is brought out on a status pin. The core's own read and write strobes pass through the same bus status encoder, so one two-bit code describes every bus cycle. Both request inputs are asynchronous. Each passes through a synchronizer whose depth is a parameter, and the synchronizer for the maskable input can be bypassed with a parameter.

Top module: `int_resp_ctrl`

## Requirements
- R1: After reset is released: all three strobes are high, `bus_code` is 00, `ie_stat_n` is high (interrupts disabled) and `int_pend` is low.
- R2: `ie_stat_n` is always the inverse of the interrupt-enable flag. A pulse on `ie_set` sets the flag and a pulse on `ie_clr` clears it.
- R3: Each high-to-low transition of `nmi_in_n` causes exactly one non-maskable response. Holding the input low afterwards causes no further response.
- R4: A detected non-maskable edge stays pending (`int_pend` high) for as long as the sequencer withholds `boundary`. It is serviced once `boundary` is raised.
- R5: A low level on `irq_in_n` requests a response only while the enable flag is set. With the flag clear, the input is ignored: `int_pend` stays low and no response starts.
- R6: A response starts only in a cycle where `boundary` and `int_pend` are both high. `int_pend` is low while a response is in progress.
- R7: `ack_any_n` is low for exactly RESP_CYCLES consecutive cycles (3 by default) for every response.
- R8: `ack_nmi_n` is low for the whole of a non-maskable response. It stays high during a maskable response.
- R9: `vec_rd_n` is low and `bus_code` is 01 only in the last cycle of a response.
- R10: Outside the vector cycle, `bus_code` is 10 when `core_wr` is high, 11 when only `core_rd` is high, and 00 otherwise. The vector-read code 01 overrides the core strobes.
- R11: When both request types are pending as a response starts, the non-maskable request is served first.
- R12: Entering a response clears the enable flag, so `ie_stat_n` is high from the first response cycle. A maskable request that is still held low is not taken again until `ie_set` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the block to idle |
| nmi_in_n | input | 1 | Non-maskable request, falling-edge triggered, asynchronous |
| irq_in_n | input | 1 | Maskable request, low-level active, asynchronous |
| ie_set | input | 1 | Pulse that sets the interrupt-enable flag |
| ie_clr | input | 1 | Pulse that clears the interrupt-enable flag |
| boundary | input | 1 | Sequencer is at an instruction boundary and will accept a response |
| core_rd | input | 1 | Core performs a memory read this cycle |
| core_wr | input | 1 | Core performs a memory write this cycle |
| int_pend | output | 1 | A serviceable request is waiting (idle only) |
| ack_any_n | output | 1 | Low during any response |
| ack_nmi_n | output | 1 | Low during a non-maskable response |
| vec_rd_n | output | 1 | Low during the vector-read cycle |
| bus_code | output | 2 | Bus status code: 00 idle, 01 vector read, 10 write, 11 read |
| ie_stat_n | output | 1 | Inverted interrupt-enable flag |

## Verification
The hardest situation to reach is the one where both request types are pending together as a response opens. Normally whichever request arrives first is taken at the next boundary. To reach it, the stimulus holds `boundary` low, enables interrupts and holds the maskable input low, and then pulses the non-maskable input. It checks that the edge stays latched, then raises `boundary` and expects a non-maskable response. The maskable response follows only after the enable flag has been set again.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RESP = 1'b1
   } resp_st_e;

   typedef enum logic [1:0] {
      BC_IDLE = 2'b00,
      BC_VEC  = 2'b01,
      BC_WR   = 2'b10,
      BC_RD   = 2'b11
   } bus_code_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("irq_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= {STAGES{RST_VAL}};
      end else begin
         sr[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            sr[i] <= sr[i-1];
         end
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
   import irq_ack_pkg::*;
#(
   parameter int RESP_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_pend,
   input  logic irq_lvl,
   input  logic ie_set,
   input  logic ie_clr,
   input  logic boundary,
   output logic int_pend,
   output logic nmi_take,
   output logic in_resp,
   output logic is_nmi,
   output logic vec_cyc,
   output logic ie
);
   localparam int CW = (RESP_CYCLES > 2) ? $clog2(RESP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(RESP_CYCLES - 1);

   generate
      if (RESP_CYCLES < 2) begin : g_bad_len
         $error("irq_resp_seq: RESP_CYCLES must be at least 2");
      end
   endgenerate

   resp_st_e      st_q;
   logic [CW-1:0] cnt_q;
   logic          is_nmi_q;
   logic          ie_q;
   logic          irq_req;
   logic          start;

   assign irq_req  = irq_lvl & ie_q;
   assign int_pend = (st_q == ST_IDLE) & (nmi_pend | irq_req);
   assign start    = int_pend & boundary;
   assign nmi_take = start & nmi_pend;
   assign in_resp  = (st_q == ST_RESP);
   assign vec_cyc  = in_resp & (cnt_q == LAST);
   assign is_nmi   = is_nmi_q;
   assign ie       = ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         is_nmi_q <= 1'b0;
      end else if (start) begin
         st_q     <= ST_RESP;
         cnt_q    <= '0;
         is_nmi_q <= nmi_pend;
      end else if (in_resp) begin
         if (cnt_q == LAST) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ie_q <= 1'b0;
      else if (start)  ie_q <= 1'b0;
      else if (ie_clr) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
   end

   // R7
   resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_resp && !vec_cyc) |=> in_resp);
   // R7
   resp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_cyc |=> !in_resp);
   // R6
   resp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_resp) |-> $past(boundary));
   // R12
   ie_entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_resp) |-> !ie_q);
endmodule

// File: rtl/irq_bus_status.sv
module irq_bus_status
   import irq_ack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_resp,
   input  logic       is_nmi,
   input  logic       vec_cyc,
   input  logic       core_rd,
   input  logic       core_wr,
   output logic       ack_any_n,
   output logic       ack_nmi_n,
   output logic       vec_rd_n,
   output logic [1:0] bus_code
);
   bus_code_e code;

   always_comb begin
      if (vec_cyc)      code = BC_VEC;
      else if (core_wr) code = BC_WR;
      else if (core_rd) code = BC_RD;
      else              code = BC_IDLE;
   end

   assign bus_code  = code;
   assign ack_any_n = ~in_resp;
   assign ack_nmi_n = ~(in_resp & is_nmi);
   assign vec_rd_n  = ~vec_cyc;

   // R8
   nmi_in_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_nmi_n |-> !ack_any_n);
   // R9
   vec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_rd_n |-> (bus_code == 2'b01 && !ack_any_n));
   // R8
   nack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_any_n && $past(!ack_any_n)) |-> $stable(ack_nmi_n));
endmodule

// File: rtl/int_resp_ctrl.sv
module int_resp_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_SYNC    = 1'b1,
   parameter int RESP_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nmi_in_n,
   input  logic       irq_in_n,
   input  logic       ie_set,
   input  logic       ie_clr,
   input  logic       boundary,
   input  logic       core_rd,
   input  logic       core_wr,
   output logic       int_pend,
   output logic       ack_any_n,
   output logic       ack_nmi_n,
   output logic       vec_rd_n,
   output logic [1:0] bus_code,
   output logic       ie_stat_n
);
   logic nmi_s, nmi_prev_q, nmi_fall, nmi_pend_q;
   logic irq_s_n;
   logic nmi_take, in_resp, is_nmi, vec_cyc, ie;

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk(clk), .rst_n(rst_n), .d(nmi_in_n), .q(nmi_s)
   );

   generate
      if (IRQ_SYNC) begin : g_irq_sync
         irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
            .clk(clk), .rst_n(rst_n), .d(irq_in_n), .q(irq_s_n)
         );
      end else begin : g_irq_raw
         assign irq_s_n = irq_in_n;
      end
   endgenerate

   assign nmi_fall = nmi_prev_q & ~nmi_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         nmi_pend_q <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_s;
         if (nmi_fall)      nmi_pend_q <= 1'b1;
         else if (nmi_take) nmi_pend_q <= 1'b0;
      end
   end

   irq_resp_seq #(.RESP_CYCLES(RESP_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend_q), .irq_lvl(~irq_s_n),
      .ie_set(ie_set), .ie_clr(ie_clr), .boundary(boundary),
      .int_pend(int_pend), .nmi_take(nmi_take), .in_resp(in_resp),
      .is_nmi(is_nmi), .vec_cyc(vec_cyc), .ie(ie)
   );

   irq_bus_status u_bus (
      .clk(clk), .rst_n(rst_n), .in_resp(in_resp), .is_nmi(is_nmi),
      .vec_cyc(vec_cyc), .core_rd(core_rd), .core_wr(core_wr),
      .ack_any_n(ack_any_n), .ack_nmi_n(ack_nmi_n), .vec_rd_n(vec_rd_n),
      .bus_code(bus_code)
   );

   assign ie_stat_n = ~ie;

   // R4
   nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend_q && !nmi_take) |=> nmi_pend_q);
   // R11
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend_q && int_pend && boundary) |=> !ack_nmi_n);
   // R3
   nmi_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nmi_s && !nmi_prev_q && !nmi_pend_q) |=> !nmi_pend_q);
endmodule

// File: tb/tb_int_resp_ctrl.sv
module tb_int_resp_ctrl;
   logic clk = 1'b0;
   logic rst_n, nmi_in_n, irq_in_n, ie_set, ie_clr, boundary, core_rd, core_wr;
   logic int_pend, ack_any_n, ack_nmi_n, vec_rd_n, ie_stat_n;
   logic [1:0] bus_code;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   int_resp_ctrl dut (
      .clk(clk), .rst_n(rst_n), .nmi_in_n(nmi_in_n), .irq_in_n(irq_in_n),
      .ie_set(ie_set), .ie_clr(ie_clr), .boundary(boundary),
      .core_rd(core_rd), .core_wr(core_wr), .int_pend(int_pend),
      .ack_any_n(ack_any_n), .ack_nmi_n(ack_nmi_n), .vec_rd_n(vec_rd_n),
      .bus_code(bus_code), .ie_stat_n(ie_stat_n)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ie(input bit set);
      if (set) ie_set = 1'b1; else ie_clr = 1'b1;
      cyc(1);
      ie_set = 1'b0;
      ie_clr = 1'b0;
   endtask

   // waits for a response and checks every cycle of it
   task automatic run_resp(input bit exp_nmi, input logic [1:0] base, input string tag);
      bit found = 1'b0;
      for (int k = 0; k < 20; k++) begin
         cyc(1);
         if (!ack_any_n) begin
            found = 1'b1;
            break;
         end
      end
      chk({tag, " R6 response start"}, 8'(found), 8'd1);
      if (!found) return;
      chk({tag, " R12 flag cleared on entry"}, 8'(ie_stat_n), 8'd1);
      for (int i = 0; i < 3; i++) begin
         if (i > 0) cyc(1);
         chk({tag, " R7 ack_any low"}, 8'(ack_any_n), 8'd0);
         chk({tag, " R8 ack_nmi"}, 8'(ack_nmi_n), 8'(!exp_nmi));
         chk({tag, " R9 vec_rd"}, 8'(vec_rd_n), (i == 2) ? 8'd0 : 8'd1);
         chk({tag, " R9 R10 bus_code"}, 8'(bus_code), (i == 2) ? 8'd1 : 8'(base));
      end
      cyc(1);
      chk({tag, " R7 ack_any released"}, 8'(ack_any_n), 8'd1);
   endtask

   task automatic t_reset();
      chk("R1 ack_any", 8'(ack_any_n), 8'd1);
      chk("R1 ack_nmi", 8'(ack_nmi_n), 8'd1);
      chk("R1 vec_rd", 8'(vec_rd_n), 8'd1);
      chk("R1 bus_code", 8'(bus_code), 8'd0);
      chk("R1 ie_stat_n", 8'(ie_stat_n), 8'd1);
      chk("R1 int_pend", 8'(int_pend), 8'd0);
   endtask

   task automatic t_flag();
      pulse_ie(1'b1);
      chk("R2 set", 8'(ie_stat_n), 8'd0);
      pulse_ie(1'b0);
      chk("R2 clear", 8'(ie_stat_n), 8'd1);
   endtask

   task automatic t_masked();
      boundary = 1'b1;
      irq_in_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         cyc(1);
         if (i == 7) begin
            chk("R5 masked no pend", 8'(int_pend), 8'd0);
            chk("R5 masked no ack", 8'(ack_any_n), 8'd1);
         end
      end
      irq_in_n = 1'b1;
      cyc(4);
   endtask

   task automatic t_irq();
      boundary = 1'b1;
      pulse_ie(1'b1);
      irq_in_n = 1'b0;
      run_resp(1'b0, 2'b00, "irq");
      cyc(8);
      chk("R12 held irq not retaken", 8'(ack_any_n), 8'd1);
      chk("R12 no pend while disabled", 8'(int_pend), 8'd0);
      pulse_ie(1'b1);
      run_resp(1'b0, 2'b00, "irq again");
      irq_in_n = 1'b1;
      cyc(4);
   endtask

   task automatic t_nmi_edge();
      boundary = 1'b1;
      nmi_in_n = 1'b0;
      run_resp(1'b1, 2'b00, "nmi");
      cyc(10);
      chk("R3 held low no second", 8'(ack_any_n), 8'd1);
      chk("R3 held low no pend", 8'(int_pend), 8'd0);
      nmi_in_n = 1'b1;
      cyc(4);
   endtask

   task automatic t_nmi_latch();
      boundary = 1'b0;
      nmi_in_n = 1'b0;
      cyc(1);
      nmi_in_n = 1'b1;
      cyc(10);
      chk("R4 latched pend", 8'(int_pend), 8'd1);
      chk("R6 no start without boundary", 8'(ack_any_n), 8'd1);
      boundary = 1'b1;
      run_resp(1'b1, 2'b00, "nmi latched");
      chk("R4 pend cleared after service", 8'(int_pend), 8'd0);
   endtask

   task automatic t_priority();
      boundary = 1'b0;
      pulse_ie(1'b1);
      irq_in_n = 1'b0;
      nmi_in_n = 1'b0;
      cyc(1);
      nmi_in_n = 1'b1;
      cyc(6);
      chk("R11 both pending", 8'(int_pend), 8'd1);
      boundary = 1'b1;
      run_resp(1'b1, 2'b00, "R11 nmi first");
      cyc(4);
      chk("R11 irq waits for flag", 8'(ack_any_n), 8'd1);
      pulse_ie(1'b1);
      run_resp(1'b0, 2'b00, "R11 irq second");
      irq_in_n = 1'b1;
      boundary = 1'b0;
      cyc(4);
   endtask

   task automatic t_bus();
      core_rd = 1'b1;
      cyc(1);
      chk("R10 read", 8'(bus_code), 8'd3);
      core_wr = 1'b1;
      cyc(1);
      chk("R10 write over read", 8'(bus_code), 8'd2);
      core_rd = 1'b0;
      cyc(1);
      chk("R10 write", 8'(bus_code), 8'd2);
      core_wr = 1'b0;
      cyc(1);
      chk("R10 idle", 8'(bus_code), 8'd0);
      core_rd = 1'b1;
      boundary = 1'b1;
      nmi_in_n = 1'b0;
      run_resp(1'b1, 2'b11, "R10 vector overrides read");
      nmi_in_n = 1'b1;
      core_rd = 1'b0;
      cyc(4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      nmi_in_n = 1'b1;
      irq_in_n = 1'b1;
      ie_set = 1'b0;
      ie_clr = 1'b0;
      boundary = 1'b0;
      core_rd = 1'b0;
      core_wr = 1'b0;
      cyc(4);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_flag();
      t_masked();
      t_irq();
      t_nmi_edge();
      t_nmi_latch();
      t_priority();
      t_bus();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule